// File: doc/BRIEF.md
# Programmable-Rate SPI Master Character Engine

This block is the master side of an SPI link. It derives a serial clock from the system clock through a baud-rate divider. It then moves one 8-bit character per start strobe, most significant bit first. Each bit goes out on the MOSI line while the MISO line is sampled into a receive byte. Rate, clock polarity, clock phase and the transmit byte are all taken when the character begins. A one-cycle done pulse marks the end of the character, and the received byte is presented at that point.

The serial clock period is the baud value plus one system clock. The smallest baud values are clamped to a period of four. When the period is odd, the two halves cannot be equal. The half spent at the non-idle level is then the shorter one, and the idle half takes the extra cycle. With polarity 0 the clock idles low, so the high half is the shorter. With polarity 1 the low half is the shorter. The sample edge is always the edge that leaves the idle level. Phase 1 presents each bit one half period ahead of its sample edge. Phase 0 changes MOSI at the sample edge itself. Clearing the master enable stops any character in progress and keeps new ones from starting.

Top module: `spim_master`

## Requirements
- R1: For a baud value b of 3 or more, every serial clock period of a character lasts b+1 system clock cycles (b is 7 bits wide, so periods reach 128).
- R2: Baud values 0, 1 and 2 all give a period of 4 system clock cycles.
- R3: With polarity 0 and period N, the clock is high for floor(N/2) cycles and low for ceil(N/2) cycles of each period.
- R4: With polarity 1 and period N, the clock is low for floor(N/2) cycles and high for ceil(N/2) cycles of each period.
- R5: During reset all outputs are 0. While no character is in progress, sclk_o equals the cpol_i value of the previous cycle.
- R6: MISO is captured on the system clock edge that moves sclk_o away from its idle level. That is the rising edge for polarity 0 and the falling edge for polarity 1. The eight captures fill rx_byte_o from bit 7 down to bit 0.
- R7: With phase 1, bit 7 appears on mosi_o in the cycle after the start is taken. Each later bit appears on the edge that returns sclk_o to idle at the end of the previous bit. Every bit therefore stays steady for the whole idle half before its sample edge and the whole active half after it.
- R8: With phase 0, mosi_o changes to bit k on the same edge as the k-th sample edge. It holds that value until the next sample edge, and after the character it keeps the last bit.
- R9: done_o is high for exactly one cycle, on the edge where sclk_o returns to idle after the eighth period. rx_byte_o is updated on that same edge and changes at no other time.
- R10: start_i is taken only while master_en_i is 1 and no character is in progress. This includes the done cycle. A start at any other time has no effect on any output.
- R11: If master_en_i is 0 while a character is in progress, the character is dropped on the next edge. sclk_o goes to the cpol_i level, no done pulse follows, and rx_byte_o keeps its value.
- R12: Baud, polarity, phase and transmit byte are sampled when the start is taken. Changing them during the character does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_i | input | 7 | Baud-rate value; period = value+1, minimum 4 |
| cpol_i | input | 1 | Clock polarity: idle level of sclk_o |
| cpha_i | input | 1 | Clock phase: 1 presents data half a period early |
| master_en_i | input | 1 | Enables clock generation and shifting |
| tx_byte_i | input | 8 | Character to transmit |
| start_i | input | 1 | Begins a character when idle and enabled |
| miso_i | input | 1 | Serial data from the slave |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| rx_byte_o | output | 8 | Last received character |
| done_o | output | 1 | One-cycle end-of-character pulse |

## Verification
A wrong half-period count or a mislatched divisor makes sclk_o leave its level one cycle early or late. The bench compares sclk_o on every clock, so such a fault is visible within a single period. A bit-index or shift fault shows up on mosi_o at the next bit boundary. It shows up on rx_byte_o no later than the done pulse of that character. Mishandled abort or busy state shows up as a stray done pulse or clock activity within one cycle of the offending enable or start input.

// File: rtl/spim_pkg.sv
package spim_pkg;

    // Which half of a serial clock period the sequencer is in
    typedef enum logic {
        HALF_IDLE = 1'b0,   // sclk at idle level, before the sample edge
        HALF_ACT  = 1'b1    // sclk away from idle, after the sample edge
    } half_e;

    // Shortest serial clock period in system clocks
    localparam int SPIM_MIN_PERIOD = 4;
    // Largest baud value that is clamped to the shortest period
    localparam int SPIM_SAT_BAUD   = 2;

endpackage

// File: rtl/spim_clk_div.sv
module spim_clk_div #(
    parameter int BAUD_W  = 7,
    parameter int CNT_W   = 7,
    parameter int MIN_DIV = 4,
    parameter int SAT_MAX = 2
) (
    input  logic [BAUD_W-1:0] baud_i,
    output logic [CNT_W-1:0]  idle_len_o,
    output logic [CNT_W-1:0]  act_len_o
);

    localparam int PER_W = BAUD_W + 1;

    logic [PER_W-1:0] period_d;
    logic [PER_W-1:0] ceil_half_d;

    always_comb begin
        if (baud_i <= BAUD_W'(SAT_MAX)) begin
            period_d = PER_W'(MIN_DIV);
        end else begin
            period_d = {1'b0, baud_i} + PER_W'(1);
        end
        ceil_half_d = (period_d + PER_W'(1)) >> 1;
        // idle half carries the odd cycle
        idle_len_o  = ceil_half_d[CNT_W-1:0];
        act_len_o   = period_d[CNT_W:1];
    end

endmodule

// File: rtl/spim_half_timer.sv
module spim_half_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/spim_shift_unit.sv
module spim_shift_unit #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              shift_i,
    input  logic              sample_i,
    input  logic              miso_i,
    output logic              head_o,
    output logic [DATA_W-1:0] rx_o
);

    typedef struct packed {
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i) begin
            sh_d.tx = load_data_i;
        end else if (shift_i) begin
            sh_d.tx = {sh_q.tx[DATA_W-2:0], 1'b0};
        end
        if (sample_i) begin
            sh_d.rx = {sh_q.rx[DATA_W-2:0], miso_i};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign head_o = sh_q.tx[DATA_W-1];
    assign rx_o   = sh_q.rx;

endmodule

// File: rtl/spim_master.sv
module spim_master
    import spim_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BAUD_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BAUD_W-1:0] baud_i,
    input  logic              cpol_i,
    input  logic              cpha_i,
    input  logic              master_en_i,
    input  logic [DATA_W-1:0] tx_byte_i,
    input  logic              start_i,
    input  logic              miso_i,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              done_o
);

    localparam int CNT_W    = BAUD_W;
    localparam int IDX_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int LAST_IDX = DATA_W - 1;

    typedef struct packed {
        logic              busy;
        half_e             half;
        logic [IDX_W-1:0]  bit_idx;
        logic              cpol;
        logic              cpha;
        logic [CNT_W-1:0]  idle_len;
        logic [CNT_W-1:0]  act_len;
        logic              sclk;
        logic              mosi;
        logic              done;
        logic [DATA_W-1:0] rx_byte;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [CNT_W-1:0]  idle_len_w, act_len_w;
    logic              tmr_load, tmr_zero;
    logic [CNT_W-1:0]  tmr_val;
    logic              sh_load, sh_shift, sh_sample, sh_head;
    logic [DATA_W-1:0] sh_data, sh_rx;

    spim_clk_div #(
        .BAUD_W (BAUD_W),
        .CNT_W  (CNT_W),
        .MIN_DIV(SPIM_MIN_PERIOD),
        .SAT_MAX(SPIM_SAT_BAUD)
    ) div_i (
        .baud_i    (baud_i),
        .idle_len_o(idle_len_w),
        .act_len_o (act_len_w)
    );

    spim_half_timer #(
        .CNT_W(CNT_W)
    ) tmr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .load_val_i(tmr_val),
        .zero_o    (tmr_zero)
    );

    spim_shift_unit #(
        .DATA_W(DATA_W)
    ) shf_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (sh_load),
        .load_data_i(sh_data),
        .shift_i    (sh_shift),
        .sample_i   (sh_sample),
        .miso_i     (miso_i),
        .head_o     (sh_head),
        .rx_o       (sh_rx)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.done = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        sh_load   = 1'b0;
        sh_data   = '0;
        sh_shift  = 1'b0;
        sh_sample = 1'b0;

        if (!ctl_q.busy) begin
            // idle: clock follows the live polarity setting
            ctl_d.sclk = cpol_i;
            if (start_i && master_en_i) begin
                ctl_d.busy     = 1'b1;
                ctl_d.half     = HALF_IDLE;
                ctl_d.bit_idx  = '0;
                ctl_d.cpol     = cpol_i;
                ctl_d.cpha     = cpha_i;
                ctl_d.idle_len = idle_len_w;
                ctl_d.act_len  = act_len_w;
                tmr_load       = 1'b1;
                tmr_val        = idle_len_w - CNT_W'(1);
                sh_load        = 1'b1;
                if (cpha_i) begin
                    // early data: first bit leaves now, keep the rest
                    ctl_d.mosi = tx_byte_i[DATA_W-1];
                    sh_data    = {tx_byte_i[DATA_W-2:0], 1'b0};
                end else begin
                    sh_data    = tx_byte_i;
                end
            end
        end else if (!master_en_i) begin
            // abandon the character
            ctl_d.busy = 1'b0;
            ctl_d.sclk = cpol_i;
        end else if (tmr_zero) begin
            if (ctl_q.half == HALF_IDLE) begin
                // sample edge
                ctl_d.half = HALF_ACT;
                ctl_d.sclk = ~ctl_q.cpol;
                sh_sample  = 1'b1;
                tmr_load   = 1'b1;
                tmr_val    = ctl_q.act_len - CNT_W'(1);
                if (!ctl_q.cpha) begin
                    ctl_d.mosi = sh_head;
                    sh_shift   = 1'b1;
                end
            end else begin
                // return to idle level
                ctl_d.sclk = ctl_q.cpol;
                if (ctl_q.bit_idx == IDX_W'(LAST_IDX)) begin
                    ctl_d.busy    = 1'b0;
                    ctl_d.done    = 1'b1;
                    ctl_d.rx_byte = sh_rx;
                end else begin
                    ctl_d.bit_idx = ctl_q.bit_idx + IDX_W'(1);
                    ctl_d.half    = HALF_IDLE;
                    tmr_load      = 1'b1;
                    tmr_val       = ctl_q.idle_len - CNT_W'(1);
                    if (ctl_q.cpha) begin
                        ctl_d.mosi = sh_head;
                        sh_shift   = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sclk_o    = ctl_q.sclk;
    assign mosi_o    = ctl_q.mosi;
    assign rx_byte_o = ctl_q.rx_byte;
    assign done_o    = ctl_q.done;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(rx_byte_o));

    // R11
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en_i |=> (!ctl_q.busy && !done_o));

    // R1
    sclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.busy && master_en_i && !tmr_zero) |=> $stable(sclk_o));

    // R7
    early_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.busy && ctl_q.cpha && ctl_q.half == HALF_ACT) |-> $stable(mosi_o));

    // R3
    half_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_len_w >= act_len_w) && ((idle_len_w - act_len_w) <= CNT_W'(1))
        && (({1'b0, idle_len_w} + {1'b0, act_len_w}) >= (CNT_W+1)'(SPIM_MIN_PERIOD)));

endmodule

// File: tb/spim_master_tb_top.sv
`timescale 1ns/1ps
module spim_master_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] baud = '0;
    logic       cpol = 1'b0;
    logic       cpha = 1'b0;
    logic       master_en = 1'b0;
    logic [7:0] tx = '0;
    logic       start = 1'b0;
    logic       miso = 1'b0;
    logic       sclk, mosi, done;
    logic [7:0] rx;

    always #10 clk = ~clk;   // 50 MHz

    spim_master dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_i     (baud),
        .cpol_i     (cpol),
        .cpha_i     (cpha),
        .master_en_i(master_en),
        .tx_byte_i  (tx),
        .start_i    (start),
        .miso_i     (miso),
        .sclk_o     (sclk),
        .mosi_o     (mosi),
        .rx_byte_o  (rx),
        .done_o     (done)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    finished = 0;
    string tag = "R5";

    // reference model: each future cycle of a character queued as a step
    typedef struct packed {
        logic sclk;
        logic upd;
        logic val;
        logic smp;
        logic last;
    } step_t;

    step_t      steps[$];
    logic       e_sclk = 0, e_mosi = 0, e_done = 0;
    logic [7:0] e_rx = '0, m_rx = '0;

    function automatic step_t mk(logic s, logic u, logic v, logic sm, logic l);
        step_t r;
        r.sclk = s; r.upd = u; r.val = v; r.smp = sm; r.last = l;
        return r;
    endfunction

    task automatic plan_char();
        int per, hi, lo;
        per = (int'(baud) < 3) ? 4 : int'(baud) + 1;
        hi  = (per + 1) / 2;
        lo  = per / 2;
        if (cpha) e_mosi = tx[7];
        for (int k = 0; k < 8; k++) begin
            repeat (hi - 1) steps.push_back(mk(cpol, 0, 0, 0, 0));
            steps.push_back(mk(~cpol, ~cpha, tx[7-k], 1, 0));
            repeat (lo - 1) steps.push_back(mk(~cpol, 0, 0, 0, 0));
            steps.push_back(mk(cpol, cpha && (k < 7), (k < 7) ? tx[6-k] : 1'b0, 0, k == 7));
        end
    endtask

    always @(posedge clk) begin : model_p
        step_t s;
        if (!rst_n) begin
            e_sclk = 0; e_mosi = 0; e_done = 0; e_rx = '0; m_rx = '0;
            steps.delete();
        end else begin
            e_done = 0;
            if (steps.size() != 0) begin
                if (!master_en) begin
                    steps.delete();
                    e_sclk = cpol;
                end else begin
                    s = steps.pop_front();
                    e_sclk = s.sclk;
                    if (s.upd) e_mosi = s.val;
                    if (s.smp) m_rx = {m_rx[6:0], miso};
                    if (s.last) begin
                        e_done = 1;
                        e_rx = m_rx;
                    end
                end
            end else begin
                e_sclk = cpol;
                if (start && master_en) plan_char();
            end
        end
    end

    task automatic cmp1(string what, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            cmp1("sclk_o", {7'd0, sclk}, {7'd0, e_sclk});
            cmp1("mosi_o", {7'd0, mosi}, {7'd0, e_mosi});
            cmp1("done_o", {7'd0, done}, {7'd0, e_done});
            cmp1("rx_byte_o", rx, e_rx);
        end
        miso = 1'($urandom_range(0, 1));
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    // called at a negedge; returns one negedge later
    task automatic kick(int b, logic pol, logic ph, logic [7:0] d);
        baud = 7'(b); cpol = pol; cpha = ph; tx = d; start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_done();
        int g = 0;
        while (!e_done && g < 5000) begin
            @(negedge clk);
            g++;
        end
    endtask

    task automatic char(int b, logic pol, logic ph, logic [7:0] d);
        kick(b, pol, ph, d);
        wait_done();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        // reset state (R5)
        repeat (4) @(negedge clk);
        tag = "R5";
        cmp1("reset sclk_o", {7'd0, sclk}, 8'd0);
        cmp1("reset mosi_o", {7'd0, mosi}, 8'd0);
        cmp1("reset done_o", {7'd0, done}, 8'd0);
        cmp1("reset rx_byte_o", rx, 8'd0);
        rst_n = 1;
        master_en = 1;
        @(negedge clk);
        // R5: idle clock tracks polarity
        for (int i = 0; i < 6; i++) begin
            cpol = i[0];
            @(negedge clk);
        end
        cpol = 0;
        @(negedge clk);

        tag = "R2";
        char(0, 0, 1, 8'hA5);
        char(1, 0, 1, 8'h5A);
        char(2, 1, 0, 8'hC3);

        tag = "R1";
        char(3, 0, 0, 8'h81);
        char(7, 1, 1, 8'h7E);
        char(127, 0, 1, 8'h96);

        tag = "R3";
        char(4, 0, 0, 8'hF0);
        char(10, 0, 1, 8'h0F);
        char(126, 0, 0, 8'h33);

        tag = "R4";
        char(4, 1, 1, 8'hCC);
        char(126, 1, 0, 8'h55);

        tag = "R7";
        char(5, 1, 1, 8'hA5);
        char(8, 0, 1, 8'h01);

        tag = "R8";
        char(6, 0, 0, 8'h3C);
        char(9, 1, 0, 8'h80);

        tag = "R6";
        for (int i = 0; i < 6; i++) begin
            char(3 + i, i[0], i[1], 8'($urandom_range(0, 255)));
        end

        tag = "R9";
        kick(3, 0, 1, 8'h12);
        wait_done();
        kick(4, 1, 0, 8'h34);
        wait_done();
        kick(0, 0, 1, 8'h56);
        wait_done();
        repeat (3) @(negedge clk);

        tag = "R10";
        master_en = 0;
        kick(3, 0, 1, 8'hFF);
        repeat (30) @(negedge clk);
        master_en = 1;
        @(negedge clk);
        kick(5, 0, 1, 8'h69);
        repeat (7) @(negedge clk);
        kick(3, 1, 0, 8'h00);
        wait_done();
        repeat (3) @(negedge clk);

        tag = "R11";
        kick(9, 1, 1, 8'hB7);
        repeat (23) @(negedge clk);
        master_en = 0;
        repeat (3) @(negedge clk);
        master_en = 1;
        repeat (4) @(negedge clk);
        char(3, 0, 0, 8'h4D);

        tag = "R12";
        kick(11, 0, 1, 8'hE1);
        repeat (9) @(negedge clk);
        baud = 7'd3; cpol = 1; cpha = 0; tx = 8'h00;
        repeat (20) @(negedge clk);
        cpol = 0;
        wait_done();
        repeat (5) @(negedge clk);

        finish_run();
    end

endmodule